// File: doc/BRIEF.md
# Programmable IDE PIO Strobe Timer

This block times programmed-I/O transfers for a local-bus IDE controller. Software reaches it through a byte-wide host port with four offsets: two timing registers, a read-only configuration register and a control register. Each timing byte encodes an active (strobe-asserted) length and a recovery length, both in bus clocks. The two fields are stored as offsets subtracted from fixed maxima. The maxima depend on the controller variant and, for the single-channel variant, on a bus-speed strap.

A requester presents a transfer that names a channel, a drive and a direction. Once it is accepted, the block picks one timing register, decodes it and asserts the read or write strobe for the active count. It then holds off the next transfer for the recovery count. A parameter chooses between the dual-channel variant, which has two timers and a control register, and the single-channel variant, which has one timer. In the dual variant a control bit decides whether the two timers are assigned per drive or per channel.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset, `req_ready` is 1 and both strobes are 0. Every timer holds its slowest code: 0x00 in the dual variant and 0x08 in the single variant. The control register reads 0x8F.
- R2: Offset 0 is timer A and offset 2 is timer B (dual variant only). Either timer reads back exactly the byte last written to it. `hp_rdata` shows the register that `hp_addr` selects in the same cycle.
- R3: Offset 1 is read-only. Bits 7:4 hold the identity code: 1100 in the single variant, and the `DUAL_ID` parameter (default 1010) in the dual variant. Bit 3 follows `strap_disabled` in the single variant and is 1 in the dual variant. Bit 2 follows `strap_slow_bus`, bit 1 follows `strap_upper_base` and bit 0 follows `strap_ide_primary`.
- R4: The control register at offset 3 (dual variant) stores bits 7:4 and bit 0 as written. Bits 3:1 always read as 1.
- R5: In the dual variant, the active length in clocks is 17 minus timing bits 3:0.
- R6: In the dual variant, the recovery length is 15 minus timing bits 7:4. Bit values 14 and 15 both give 2 clocks.
- R7: In the single variant with `strap_slow_bus`=1, the active length is 9 minus bits 2:0 and the recovery length is 15 minus bits 7:4. Bit 3 has no effect on timing.
- R8: In the single variant with `strap_slow_bus`=0, the active length is 8 minus bits 2:0 and the recovery length is 18 minus bits 7:4.
- R9: Timer choice in the dual variant depends on control bit 0. When it is 1, drive 0 uses timer A and drive 1 uses timer B. When it is 0, channel 0 uses timer A and channel 1 uses timer B. The single variant always uses timer A, reads 0 at offsets 2 and 3, and ignores writes to them.
- R10: A transfer is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle, `rd_stb` (when `req_write`=0) or `wr_stb` (when `req_write`=1) is 1 for exactly the active length. `req_ready` then stays 0 for the recovery length and returns to 1 after it.
- R11: The timing byte is captured at acceptance. A timer written while a transfer is running changes only later transfers.
- R12: While a transfer is running, `req_ready` is 0 and a held request waits. At most one strobe is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hp_addr | input | 2 | Host register offset |
| hp_wr | input | 1 | Host write enable |
| hp_wdata | input | 8 | Host write data |
| hp_rdata | output | 8 | Host read data for `hp_addr` |
| strap_slow_bus | input | 1 | 1 when the bus runs at 33 MHz or slower |
| strap_upper_base | input | 1 | Controller base select strap |
| strap_ide_primary | input | 1 | IDE base select strap |
| strap_disabled | input | 1 | Single-variant disable strap |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 for a write transfer, 0 for a read transfer |
| req_chan | input | 1 | Channel of the request |
| req_drive | input | 1 | Drive of the request |
| req_ready | output | 1 | Block can accept a transfer |
| rd_stb | output | 1 | Read strobe, active high |
| wr_stb | output | 1 | Write strobe, active high |

## Verification
The assertions assume that the requester holds `req_valid` and its attributes steady until an acceptance edge. They also assume that the straps do not change while the configuration register is being read. The bench drives every input a few nanoseconds after a rising edge and changes a request only after it sees `req_ready` high. It writes the host port only to the four defined offsets. A timer is rewritten in the middle of a strobe so that the capture-at-acceptance rule is exercised.

// File: rtl/pst_pkg.sv
// Shared types and constants for the PIO strobe timer.
// Assumes counts fit in five bits (maximum 18 clocks).
package pst_pkg;
    localparam int CNT_W = 5;

    typedef logic [CNT_W-1:0] pst_cnt_t;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ACTIVE = 2'd1,
        SEQ_RECOV  = 2'd2
    } seq_state_t;

    localparam logic [1:0] OFS_TIMER_A = 2'd0;
    localparam logic [1:0] OFS_CONFIG  = 2'd1;
    localparam logic [1:0] OFS_TIMER_B = 2'd2;
    localparam logic [1:0] OFS_CONTROL = 2'd3;

    localparam logic [7:0] CTRL_RESET   = 8'h8F;
    localparam logic [3:0] SINGLE_IDENT = 4'b1100;
endpackage

// File: rtl/pst_regs.sv
// Host register file and timer selection.
// Holds timer A, and in the dual variant also timer B and control.
// Assumes one host access per cycle; reads are combinational.
module pst_regs
    import pst_pkg::*;
#(
    parameter bit         DUAL    = 1'b1,
    parameter logic [3:0] DUAL_ID = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       strap_slow_bus,
    input  logic       strap_upper_base,
    input  logic       strap_ide_primary,
    input  logic       strap_disabled,
    input  logic       sel_chan,
    input  logic       sel_drive,
    output logic [7:0] sel_timing
);
    localparam logic [7:0] SLOW_CODE = DUAL ? 8'h00 : 8'h08;
    localparam logic [3:0] IDENT     = DUAL ? DUAL_ID : SINGLE_IDENT;

    logic [7:0] timer_a_q;
    logic       bit3_cfg;
    logic [7:0] config_val;

    // Timer A storage, common to both variants.
    always_ff @(posedge clk) begin
        if (!rst_n)
            timer_a_q <= SLOW_CODE;
        else if (wr && addr == OFS_TIMER_A)
            timer_a_q <= wdata;
    end

    assign config_val = {IDENT, bit3_cfg, strap_slow_bus, strap_upper_base, strap_ide_primary};

    generate
        if (DUAL) begin : g_dual
            logic [7:0] timer_b_q;
            logic [7:0] ctrl_q;
            logic       unused_dis;

            assign unused_dis = strap_disabled;
            assign bit3_cfg   = 1'b1;

            // Timer B storage.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    timer_b_q <= SLOW_CODE;
                else if (wr && addr == OFS_TIMER_B)
                    timer_b_q <= wdata;
            end

            // Control storage with bits 3:1 pinned high.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ctrl_q <= CTRL_RESET;
                else if (wr && addr == OFS_CONTROL)
                    ctrl_q <= {wdata[7:4], 3'b111, wdata[0]};
            end

            // Pick the timer: per drive when control bit 0 is set, else per channel.
            always_comb begin
                if (ctrl_q[0] ? sel_drive : sel_chan)
                    sel_timing = timer_b_q;
                else
                    sel_timing = timer_a_q;
            end

            // Host read multiplexer.
            always_comb begin
                case (addr)
                    OFS_TIMER_A: rdata = timer_a_q;
                    OFS_CONFIG:  rdata = config_val;
                    OFS_TIMER_B: rdata = timer_b_q;
                    default:     rdata = ctrl_q;
                endcase
            end
        end else begin : g_single
            logic unused_sel;

            assign unused_sel = sel_chan ^ sel_drive;
            assign bit3_cfg   = strap_disabled;
            assign sel_timing = timer_a_q;

            // Host read multiplexer; upper offsets are absent.
            always_comb begin
                case (addr)
                    OFS_TIMER_A: rdata = timer_a_q;
                    OFS_CONFIG:  rdata = config_val;
                    default:     rdata = 8'h00;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/pst_decode.sv
// Turns a timing byte into active and recovery clock counts.
// Variant-specific offsets from fixed maxima; purely combinational.
module pst_decode
    import pst_pkg::*;
#(
    parameter bit DUAL = 1'b1
) (
    input  logic [7:0] timing,
    input  logic       slow_bus,
    output pst_cnt_t   act_cnt,
    output pst_cnt_t   rec_cnt
);
    logic [3:0] hi;
    assign hi = timing[7:4];

    generate
        if (DUAL) begin : g_dual
            logic unused_slow;
            assign unused_slow = slow_bus;

            // Active is 17 minus the low nibble; recovery is floored at 2.
            always_comb begin
                act_cnt = CNT_W'(17) - {1'b0, timing[3:0]};
                if (hi > 4'd13)
                    rec_cnt = CNT_W'(2);
                else
                    rec_cnt = CNT_W'(15) - {1'b0, hi};
            end
        end else begin : g_single
            logic unused_b3;
            assign unused_b3 = timing[3];

            // Maxima depend on the bus-speed strap; bit 3 is not decoded.
            always_comb begin
                if (slow_bus) begin
                    act_cnt = CNT_W'(9) - {2'b00, timing[2:0]};
                    rec_cnt = CNT_W'(15) - {1'b0, hi};
                end else begin
                    act_cnt = CNT_W'(8) - {2'b00, timing[2:0]};
                    rec_cnt = CNT_W'(18) - {1'b0, hi};
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pst_seq.sv
// Transfer sequencer: accepts a request, runs the strobe for the
// active count, then the recovery window. Counts are captured at
// acceptance and assumed to be at least 1 for active.
module pst_seq
    import pst_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  logic     req_write,
    input  pst_cnt_t act_cnt,
    input  pst_cnt_t rec_cnt,
    output logic     req_ready,
    output logic     rd_stb,
    output logic     wr_stb
);
    seq_state_t state_q;
    pst_cnt_t   cnt_q;
    pst_cnt_t   rec_q;
    logic       is_wr_q;

    // State, down-counter and captured attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            rec_q   <= '0;
            is_wr_q <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        state_q <= SEQ_ACTIVE;
                        cnt_q   <= act_cnt - CNT_W'(1);
                        rec_q   <= rec_cnt;
                        is_wr_q <= req_write;
                    end
                end
                SEQ_ACTIVE: begin
                    if (cnt_q == '0) begin
                        if (rec_q == '0) begin
                            state_q <= SEQ_IDLE;
                        end else begin
                            state_q <= SEQ_RECOV;
                            cnt_q   <= rec_q - CNT_W'(1);
                        end
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                SEQ_RECOV: begin
                    if (cnt_q == '0)
                        state_q <= SEQ_IDLE;
                    else
                        cnt_q <= cnt_q - CNT_W'(1);
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Output decode from state.
    always_comb begin
        req_ready = (state_q == SEQ_IDLE);
        rd_stb    = (state_q == SEQ_ACTIVE) && !is_wr_q;
        wr_stb    = (state_q == SEQ_ACTIVE) &&  is_wr_q;
    end
endmodule

// File: rtl/pio_strobe_timer.sv
// Top level of the programmable IDE PIO strobe timer.
// Connects the host register file, the timing decoder and the
// transfer sequencer. DUAL selects the two-timer variant.
module pio_strobe_timer
    import pst_pkg::*;
#(
    parameter bit         DUAL    = 1'b1,
    parameter logic [3:0] DUAL_ID = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] hp_addr,
    input  logic       hp_wr,
    input  logic [7:0] hp_wdata,
    output logic [7:0] hp_rdata,
    input  logic       strap_slow_bus,
    input  logic       strap_upper_base,
    input  logic       strap_ide_primary,
    input  logic       strap_disabled,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       req_chan,
    input  logic       req_drive,
    output logic       req_ready,
    output logic       rd_stb,
    output logic       wr_stb
);
    logic [7:0] sel_timing;
    pst_cnt_t   act_cnt;
    pst_cnt_t   rec_cnt;

    pst_regs #(.DUAL(DUAL), .DUAL_ID(DUAL_ID)) u_regs (
        .clk               (clk),
        .rst_n             (rst_n),
        .addr              (hp_addr),
        .wr                (hp_wr),
        .wdata             (hp_wdata),
        .rdata             (hp_rdata),
        .strap_slow_bus    (strap_slow_bus),
        .strap_upper_base  (strap_upper_base),
        .strap_ide_primary (strap_ide_primary),
        .strap_disabled    (strap_disabled),
        .sel_chan          (req_chan),
        .sel_drive         (req_drive),
        .sel_timing        (sel_timing)
    );

    pst_decode #(.DUAL(DUAL)) u_dec (
        .timing   (sel_timing),
        .slow_bus (strap_slow_bus),
        .act_cnt  (act_cnt),
        .rec_cnt  (rec_cnt)
    );

    pst_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .act_cnt   (act_cnt),
        .rec_cnt   (rec_cnt),
        .req_ready (req_ready),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb)
    );
endmodule

// File: rtl/pst_checker.sv
// Protocol checker for pio_strobe_timer, bound to every instance.
module pst_checker #(
    parameter bit DUAL = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] hp_addr,
    input logic       hp_wr,
    input logic [7:0] hp_wdata,
    input logic [7:0] hp_rdata,
    input logic       req_valid,
    input logic       req_write,
    input logic       req_ready,
    input logic       rd_stb,
    input logic       wr_stb
);
    a_r2_timer_a_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_wr && hp_addr == 2'd0) |=> (hp_addr != 2'd0 || hp_rdata == $past(hp_wdata)));

    a_r4_ctrl_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (DUAL && hp_addr == 2'd3) |-> hp_rdata[3:1] == 3'b111);

    a_r10_accept_starts_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rd_stb || wr_stb));

    a_r10_write_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> wr_stb);

    a_r10_read_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rd_stb);

    a_r12_strobe_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |-> !req_ready);

    a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rd_stb, wr_stb}) <= 1);

    a_r12_no_kind_switch: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !wr_stb);
endmodule

bind pio_strobe_timer pst_checker #(.DUAL(DUAL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hp_addr   (hp_addr),
    .hp_wr     (hp_wr),
    .hp_wdata  (hp_wdata),
    .hp_rdata  (hp_rdata),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb)
);

// File: tb/sim_pio_strobe_timer.sv
module sim_pio_strobe_timer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // dual-variant instance signals
    logic [1:0] hp_addr = 2'd0;
    logic       hp_wr = 1'b0;
    logic [7:0] hp_wdata = 8'h00;
    logic [7:0] hp_rdata;
    logic req_valid = 1'b0, req_write = 1'b0, req_chan = 1'b0, req_drive = 1'b0;
    logic req_ready, rd_stb, wr_stb;

    // single-variant instance signals
    logic [1:0] s_addr = 2'd0;
    logic       s_wr = 1'b0;
    logic [7:0] s_wdata = 8'h00;
    logic [7:0] s_rdata;
    logic s_slow = 1'b1;
    logic s_valid = 1'b0;
    logic s_ready, s_rd, s_wrs;

    pio_strobe_timer #(.DUAL(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .hp_addr(hp_addr), .hp_wr(hp_wr),
        .hp_wdata(hp_wdata), .hp_rdata(hp_rdata),
        .strap_slow_bus(1'b1), .strap_upper_base(1'b0),
        .strap_ide_primary(1'b1), .strap_disabled(1'b1),
        .req_valid(req_valid), .req_write(req_write), .req_chan(req_chan),
        .req_drive(req_drive), .req_ready(req_ready), .rd_stb(rd_stb), .wr_stb(wr_stb));

    pio_strobe_timer #(.DUAL(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .hp_addr(s_addr), .hp_wr(s_wr),
        .hp_wdata(s_wdata), .hp_rdata(s_rdata),
        .strap_slow_bus(s_slow), .strap_upper_base(1'b1),
        .strap_ide_primary(1'b0), .strap_disabled(1'b1),
        .req_valid(s_valid), .req_write(1'b0), .req_chan(1'b0),
        .req_drive(1'b0), .req_ready(s_ready), .rd_stb(s_rd), .wr_stb(s_wrs));

    typedef struct {
        int    act;
        int    rec;
        bit    wr;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    task automatic check(bit ok, string tag, int actual, int expected);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, actual, actual, expected, expected);
        end
    endtask

    // reference decode for the dual variant (R5, R6)
    function automatic int d_act(logic [7:0] t); return 17 - int'(t[3:0]); endfunction
    function automatic int d_rec(logic [7:0] t);
        return (t[7:4] >= 4'd14) ? 2 : 15 - int'(t[7:4]);
    endfunction

    task automatic hwrite(logic [1:0] a, logic [7:0] d);
        @(posedge clk); #2;
        hp_addr = a; hp_wdata = d; hp_wr = 1'b1;
        @(posedge clk); #2;
        hp_wr = 1'b0;
    endtask

    task automatic hread(logic [1:0] a, logic [7:0] exp, string tag);
        @(posedge clk); #2;
        hp_addr = a;
        @(negedge clk);
        check(hp_rdata == exp, tag, hp_rdata, exp);
    endtask

    task automatic swrite(logic [1:0] a, logic [7:0] d);
        @(posedge clk); #2;
        s_addr = a; s_wdata = d; s_wr = 1'b1;
        @(posedge clk); #2;
        s_wr = 1'b0;
    endtask

    task automatic sread(logic [1:0] a, logic [7:0] exp, string tag);
        @(posedge clk); #2;
        s_addr = a;
        @(negedge clk);
        check(s_rdata == exp, tag, s_rdata, exp);
    endtask

    // driver: pushes the expected shape, then presents the request until accepted
    task automatic issue(bit ch, bit drv, bit w, int a, int r, string tag);
        exp_t e;
        e.act = a; e.rec = r; e.wr = w; e.tag = tag;
        sb_q.push_back(e);
        @(posedge clk); #2;
        req_valid = 1'b1; req_write = w; req_chan = ch; req_drive = drv;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #2;
        req_valid = 1'b0;
    endtask

    // monitor: measures each strobe and recovery window, compares with the queue
    bit mon_busy = 1'b0;
    bit mon_wr = 1'b0;
    int mon_act = 0;
    int mon_rec = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (rd_stb || wr_stb) begin
                    if (!mon_busy) begin
                        mon_busy = 1'b1; mon_act = 0; mon_rec = 0; mon_wr = wr_stb;
                    end
                    mon_act++;
                end else if (mon_busy && !req_ready) begin
                    mon_rec++;
                end else if (mon_busy) begin
                    exp_t e;
                    mon_busy = 1'b0;
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R10 unexpected transfer", mon_act, 0);
                    end else begin
                        e = sb_q.pop_front();
                        check(mon_act == e.act, {e.tag, " active"}, mon_act, e.act);
                        check(mon_rec == e.rec, {e.tag, " recovery"}, mon_rec, e.rec);
                        check(mon_wr == e.wr, {e.tag, " strobe kind"}, int'(mon_wr), int'(e.wr));
                    end
                end
            end
        end
    end

    // direct measurement for the single-variant instance
    task automatic s_cycle(int a, int r, string tag);
        int na = 0;
        int nr = 0;
        @(posedge clk); #2;
        s_valid = 1'b1;
        do @(negedge clk); while (!s_ready);
        @(posedge clk); #2;
        s_valid = 1'b0;
        @(negedge clk);
        while (s_rd) begin na++; @(negedge clk); end
        while (!s_ready) begin nr++; @(negedge clk); end
        check(na == a, {tag, " active"}, na, a);
        check(nr == r, {tag, " recovery"}, nr, r);
    endtask

    initial begin
        #(20 * 150000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check({rd_stb, wr_stb} == 2'b00, "R1 strobes low", {rd_stb, wr_stb}, 0);
        hread(2'd0, 8'h00, "R1 timer A reset");
        hread(2'd2, 8'h00, "R1 timer B reset");
        hread(2'd3, 8'h8F, "R1 control reset");
        sread(2'd0, 8'h08, "R1 single timer reset");

        // R3 configuration register, writes ignored
        hread(2'd1, 8'hAD, "R3 dual config");
        hwrite(2'd1, 8'h00);
        hread(2'd1, 8'hAD, "R3 dual config after write");
        sread(2'd1, 8'hCE, "R3 single config slow");

        // R5 R6 R10 slowest timing on a read
        issue(1'b0, 1'b0, 1'b0, 17, 15, "R5 R6 R10 reset timing read");

        // R2 readback
        hwrite(2'd0, 8'h3C);
        hread(2'd0, 8'h3C, "R2 timer A readback");
        hwrite(2'd2, 8'hD5);
        hread(2'd2, 8'hD5, "R2 timer B readback");

        // R9 per-drive mode (control bit 0 = 1 at reset)
        issue(1'b1, 1'b0, 1'b1, d_act(8'h3C), d_rec(8'h3C), "R9 per-drive drive0 uses A");
        issue(1'b0, 1'b1, 1'b0, d_act(8'hD5), d_rec(8'hD5), "R9 per-drive drive1 uses B");

        // R4 control fixed bits, then R9 per-channel mode
        hwrite(2'd3, 8'h50);
        hread(2'd3, 8'h5E, "R4 control bits 3:1 forced");
        issue(1'b0, 1'b1, 1'b0, d_act(8'h3C), d_rec(8'h3C), "R9 per-channel chan0 uses A");
        issue(1'b1, 1'b0, 1'b1, d_act(8'hD5), d_rec(8'hD5), "R9 per-channel chan1 uses B");

        // R6 clamp of high nibble 14 and 15; R5 minimum active
        hwrite(2'd0, 8'hEF);
        issue(1'b0, 1'b0, 1'b0, 2, 2, "R5 R6 lo15 hi14");
        hwrite(2'd0, 8'hF0);
        issue(1'b0, 1'b0, 1'b1, 17, 2, "R6 hi15 clamp");

        // R11 rewrite during strobe affects only the next transfer; R12 back-to-back hold
        hwrite(2'd0, 8'h00);
        issue(1'b0, 1'b0, 1'b1, 17, 15, "R11 transfer in flight keeps old timing");
        hwrite(2'd0, 8'hFF);
        issue(1'b0, 1'b0, 1'b0, 2, 2, "R11 R12 held request uses new timing");

        // R7 single variant slow bus
        s_cycle(9, 15, "R7 single slow reset code");
        swrite(2'd0, 8'h5F);
        sread(2'd0, 8'h5F, "R2 single readback");
        s_cycle(2, 10, "R7 single slow 0x5F");
        swrite(2'd0, 8'hF0);
        s_cycle(9, 0, "R7 single slow bit3 clear, zero recovery");

        // R9 single variant upper offsets absent
        swrite(2'd2, 8'h77);
        sread(2'd2, 8'h00, "R9 single offset 2 reads 0");
        swrite(2'd3, 8'h77);
        sread(2'd3, 8'h00, "R9 single offset 3 reads 0");
        s_cycle(9, 0, "R9 single timing unchanged by ignored writes");

        // R8 single variant fast bus
        @(posedge clk); #2 s_slow = 1'b0;
        sread(2'd1, 8'hCA, "R3 single config fast");
        swrite(2'd0, 8'h08);
        s_cycle(8, 18, "R8 single fast 0x08");
        swrite(2'd0, 8'hFF);
        s_cycle(1, 3, "R8 single fast 0xFF");

        // drain scoreboard
        repeat (60) @(negedge clk);
        check(sb_q.size() == 0, "R10 all transfers observed", sb_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule